// File: doc/BRIEF.md
# Burst SRAM Access Controller

This block is the synchronous control front end of a burst static RAM. It contains a small word array so that it can be simulated on its own. Two address strobes can open an access, and either one works. The processor-side strobe always opens a read. The controller-side strobe opens a read or a write, depending on the write enables sampled on the same edge. Once an access is open, an advance input walks a 2-bit burst counter through four word addresses. The counter follows either an interleaved order or a linear order.

Writes are sized per 9-bit byte lane. Each data word holds two lanes. Read data comes from one of two paths:

- **Pipelined:** the data appears one clock after the address is registered.
- **Flow-through:** the data appears right after the edge that registers the address.

An output-enable signal for an external tristate comes with the data. It falls on deselect, on byte-write activity and when the asynchronous output-enable input is released.

Top module: `bsram_ctrl`

## Requirements
- R1: With `strb_cpu_n` low and `sel_main_n` low on an edge, an access opens at `addr`. The access is a read. Nothing is written, whatever `wr_all_n`, `wr_byte_n` and `lane_n` are.
- R2: While `sel_main_n` is high, a low `strb_cpu_n` is not a strobe. A low `strb_ctl_n` is still a strobe in that case, and it deselects.
- R3: A low `strb_ctl_n` opens an access only when `strb_cpu_n` is high or blocked. The write enables sampled on that edge decide whether it writes at `addr`.
- R4: On an edge that accepts `strb_cpu_n`, `adv_n` and the byte write inputs have no effect. The access uses `addr` unchanged, and the output drivers are not blocked.
- R5: On an edge with no accepted strobe and an open access:
  - `adv_n` low moves the access to the next burst address.
  - `adv_n` high repeats the current address.
  - Each such edge reads, or writes if the write enables ask for it.
- R6: Bits [1:0] of the access address are the start bits combined with a 2-bit count that wraps at 4. Bits above them stay fixed.
  - `order_xor`=1: start XOR count (interleaved order).
  - `order_xor`=0: start plus count modulo 4 (linear order).
- R7: Write decode:
  - `wr_all_n` low writes both lanes.
  - Otherwise, `wr_byte_n` low writes the lanes whose `lane_n` bit is low. `lane_n[0]` selects data bits [8:0] and `lane_n[1]` selects bits [17:9].
  - Every other combination is a read.
- R8: An edge that samples an effective byte write forces `rdata_oe` low for the following cycle, even if a pipelined read result is due in that cycle.
- R9: A strobe edge deselects when `sel_main_n` is high, `sel_lo_n` is high or `sel_hi` is low. `rdata_oe` is low one cycle after that edge. In pipelined mode the earlier read still drives for that one cycle.
- R10: Read latency depends on `pipe_sel`:
  - `pipe_sel`=1: the word at the access address appears on `rdata`, with `rdata_oe` high, after the following edge.
  - `pipe_sel`=0: it appears right after the access edge.
- R11: A low `rst_n` on an edge closes any open access and drives `rdata_oe` low.
- R12: `oe_n` high forces `rdata_oe` low without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_main_n | input | 1 | Master chip enable, active low |
| sel_lo_n | input | 1 | Secondary chip enable, active low |
| sel_hi | input | 1 | Secondary chip enable, active high |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_byte_n | input | 1 | Byte write qualifier, active low |
| lane_n | input | LANES | Per-lane write strobes, active low |
| order_xor | input | 1 | Burst order: 1 interleaved, 0 linear |
| pipe_sel | input | 1 | Read path: 1 pipelined, 0 flow-through |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Word address |
| wdata | input | LANES*BYTE_W | Write data |
| rdata | output | LANES*BYTE_W | Read data |
| rdata_oe | output | 1 | Drive enable for the external tristate |

## Verification
The bench builds the block with a 64-word array, which gives a 6-bit address. With this depth the upper address bits above the burst counter are live, so the checks can show that a wrapping burst never leaves its 4-word group. The byte-lane and width parameters stay at their defaults of two 9-bit lanes. This lets single-lane writes be checked against the untouched lane. Both burst orders are exercised at both read latencies, from an odd start offset where the two orders diverge.

// File: rtl/bsram_pkg.sv
// Shared constants and types of the burst SRAM controller.
// Assumes a 4-beat burst, so the burst counter is 2 bits wide.
package bsram_pkg;
    localparam int BYTE_W = 9;
    localparam int LANES  = 2;
    localparam int CNT_W  = 2;

    // Which address strobe, if any, is accepted on this edge.
    typedef enum logic [1:0] {
        ST_NONE = 2'd0,
        ST_CPU  = 2'd1,
        ST_CTL  = 2'd2
    } strobe_e;
endpackage

// File: rtl/bsram_cmd.sv
// Command decode of the burst SRAM controller: picks the accepted strobe,
// decides load or deselect, advance, and the effective per-lane write mask.
// Purely combinational; assumes all inputs are sampled on the rising edge.
module bsram_cmd
    import bsram_pkg::*;
#(
    parameter int LANES = bsram_pkg::LANES
)(
    input  logic             strb_cpu_n,
    input  logic             strb_ctl_n,
    input  logic             adv_n,
    input  logic             sel_main_n,
    input  logic             sel_lo_n,
    input  logic             sel_hi,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_n,
    output strobe_e          strobe,
    output logic             load,
    output logic             desel,
    output logic             step,
    output logic [LANES-1:0] wmask
);
    logic             chips_on;
    logic [LANES-1:0] raw_mask;

    // Strobe arbitration: the processor strobe needs the master enable, the controller strobe does not.
    always_comb begin
        if (!strb_cpu_n && !sel_main_n) begin
            strobe = ST_CPU;
        end else if (!strb_ctl_n) begin
            strobe = ST_CTL;
        end else begin
            strobe = ST_NONE;
        end
    end

    // Chip-select qualification of an accepted strobe.
    always_comb begin
        chips_on = !sel_main_n && !sel_lo_n && sel_hi;
        load     = (strobe != ST_NONE) && chips_on;
        desel    = (strobe != ST_NONE) && !chips_on;
        step     = (strobe == ST_NONE) && !adv_n;
    end

    // Write decode; the byte inputs are ignored on a processor-strobe edge.
    always_comb begin
        if (!wr_all_n) begin
            raw_mask = '1;
        end else if (!wr_byte_n) begin
            raw_mask = ~lane_n;
        end else begin
            raw_mask = '0;
        end
        wmask = (strobe == ST_CPU) ? '0 : raw_mask;
    end
endmodule

// File: rtl/bsram_burst.sv
// Address register and 2-bit burst counter. Loads the external address on
// an accepted strobe, steps the low bits in interleaved or linear order,
// and holds the address of the most recent access for the read port.
// Assumes AW >= 2.
module bsram_burst
    import bsram_pkg::*;
#(
    parameter int AW = 8
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_in,
    input  logic          load,
    input  logic          desel,
    input  logic          step,
    input  logic          no_strobe,
    input  logic          order_xor,
    output logic          active,
    output logic          acc_en,
    output logic [AW-1:0] acc_addr,
    output logic [AW-1:0] rd_addr
);
    logic [AW-1:0]    base_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             active_q;

    // Burst low bits from start bits and count.
    function automatic logic [CNT_W-1:0] beat_bits(input logic [CNT_W-1:0] b,
                                                   input logic [CNT_W-1:0] c,
                                                   input logic x);
        return x ? (b ^ c) : (b + c);
    endfunction

    // Access address for this edge: external on load, else next or current burst beat.
    always_comb begin
        cnt_nx   = step ? cnt_q + 1'b1 : cnt_q;
        acc_en   = load || (no_strobe && active_q);
        acc_addr = load ? addr_in
                        : {base_q[AW-1:CNT_W], beat_bits(base_q[CNT_W-1:0], cnt_nx, order_xor)};
    end

    assign active = active_q;

    // Burst state: open on load, close on deselect, count while open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            active_q <= 1'b1;
            base_q   <= addr_in;
            cnt_q    <= '0;
        end else if (desel) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            cnt_q    <= cnt_nx;
        end
    end

    // Registered address of the latest access, feeding the read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr <= '0;
        end else if (acc_en) begin
            rd_addr <= acc_addr;
        end
    end

    // R5: a suspended edge repeats the address.
    p_suspend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && no_strobe && !step) |=> $stable(rd_addr));

    // R6: a linear step adds one to the low bits and keeps the upper bits.
    p_linear_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && step && !order_xor)
        |=> (rd_addr[CNT_W-1:0] == $past(rd_addr[CNT_W-1:0]) + 1'b1)
            && (rd_addr[AW-1:CNT_W] == $past(rd_addr[AW-1:CNT_W])));
endmodule

// File: rtl/bsram_array.sv
// Word array with one synchronous byte-masked write port and one
// combinational read port. One storage bank per byte lane; no reset.
module bsram_array #(
    parameter int DEPTH  = 256,
    parameter int AW     = 8,
    parameter int BYTE_W = 9,
    parameter int LANES  = 2,
    localparam int WORD_W = BYTE_W * LANES
)(
    input  logic              clk,
    input  logic [LANES-1:0]  we_mask,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] bank [DEPTH];

        // Lane write on its own strobe.
        always_ff @(posedge clk) begin
            if (we_mask[g]) begin
                bank[waddr] <= wdata[g*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[g*BYTE_W +: BYTE_W] = bank[raddr];
    end
endmodule

// File: rtl/bsram_out.sv
// Read output stage: flow-through or one extra register stage, plus the
// tristate enable that honours deselect, byte-write blocking and oe_n.
module bsram_out #(
    parameter int WORD_W = 18
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_sel,
    input  logic              oe_n,
    input  logic              rd_now,
    input  logic              blk_now,
    input  logic [WORD_W-1:0] flow_data,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_oe
);
    logic              rd_q;
    logic              blk_q;
    logic              pipe_vld_q;
    logic [WORD_W-1:0] pipe_q;
    logic              valid;

    // Read-valid, write-block and the pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q       <= 1'b0;
            blk_q      <= 1'b0;
            pipe_vld_q <= 1'b0;
            pipe_q     <= '0;
        end else begin
            rd_q       <= rd_now;
            blk_q      <= blk_now;
            pipe_vld_q <= rd_q;
            pipe_q     <= flow_data;
        end
    end

    // Output selection and drive enable.
    always_comb begin
        rdata    = pipe_sel ? pipe_q : flow_data;
        valid    = pipe_sel ? pipe_vld_q : rd_q;
        rdata_oe = valid && !blk_q && !oe_n;
    end
endmodule

// File: rtl/bsram_ctrl.sv
// Top of the burst SRAM controller: strobe decode, burst addressing,
// byte-lane array and the selectable read path.
// Assumes pipe_sel and order_xor are held steady during an open burst.
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int BYTE_W = bsram_pkg::BYTE_W,
    parameter int LANES  = bsram_pkg::LANES,
    localparam int AW     = $clog2(DEPTH),
    localparam int WORD_W = BYTE_W * LANES
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              sel_main_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              order_xor,
    input  logic              pipe_sel,
    input  logic              oe_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_oe
);
    strobe_e           strobe;
    logic              load;
    logic              desel;
    logic              step;
    logic [LANES-1:0]  wmask;
    logic              active;
    logic              acc_en;
    logic [AW-1:0]     acc_addr;
    logic [AW-1:0]     rd_addr;
    logic [LANES-1:0]  we_mask;
    logic              rd_now;
    logic              blk_now;
    logic [WORD_W-1:0] flow_data;

    bsram_cmd #(.LANES(LANES)) u_cmd (
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .adv_n      (adv_n),
        .sel_main_n (sel_main_n),
        .sel_lo_n   (sel_lo_n),
        .sel_hi     (sel_hi),
        .wr_all_n   (wr_all_n),
        .wr_byte_n  (wr_byte_n),
        .lane_n     (lane_n),
        .strobe     (strobe),
        .load       (load),
        .desel      (desel),
        .step       (step),
        .wmask      (wmask)
    );

    bsram_burst #(.AW(AW)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_in   (addr),
        .load      (load),
        .desel     (desel),
        .step      (step),
        .no_strobe (strobe == ST_NONE),
        .order_xor (order_xor),
        .active    (active),
        .acc_en    (acc_en),
        .acc_addr  (acc_addr),
        .rd_addr   (rd_addr)
    );

    // Access type of this edge: write if any lane is selected, else read.
    always_comb begin
        we_mask = acc_en ? wmask : '0;
        rd_now  = acc_en && (wmask == '0);
        blk_now = (wmask != '0);
    end

    bsram_array #(
        .DEPTH  (DEPTH),
        .AW     (AW),
        .BYTE_W (BYTE_W),
        .LANES  (LANES)
    ) u_array (
        .clk     (clk),
        .we_mask (we_mask),
        .waddr   (acc_addr),
        .wdata   (wdata),
        .raddr   (rd_addr),
        .rdata   (flow_data)
    );

    bsram_out #(.WORD_W(WORD_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_sel  (pipe_sel),
        .oe_n      (oe_n),
        .rd_now    (rd_now),
        .blk_now   (blk_now),
        .flow_data (flow_data),
        .rdata     (rdata),
        .rdata_oe  (rdata_oe)
    );

    // R1: a processor-strobe edge never writes.
    p_cpu_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe == ST_CPU) |-> (we_mask == '0));

    // R2: controller strobe with master enable off closes the access.
    p_ctl_unblocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_ctl_n && sel_main_n) |=> !active);

    // R8: sampled byte write blocks the drivers next cycle.
    p_lane_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wmask != '0) |=> !rdata_oe);

    // R9: flow-through deselect turns drivers off after one edge.
    p_desel_flow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (desel && !pipe_sel) |=> (!rdata_oe || pipe_sel));

    // R9: pipelined deselect turns drivers off one cycle later.
    p_desel_pipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (desel && pipe_sel) |=> ##1 (!rdata_oe || !pipe_sel));
endmodule

// File: tb/bsram_ctrl_test.sv
// Directed bench for bsram_ctrl with a 64-word array.
module bsram_ctrl_test;
    localparam int DEPTH = 64;
    localparam int AW    = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        strb_cpu_n, strb_ctl_n, adv_n;
    logic        sel_main_n, sel_lo_n, sel_hi;
    logic        wr_all_n, wr_byte_n;
    logic [1:0]  lane_n;
    logic        order_xor, pipe_sel, oe_n;
    logic [AW-1:0] addr;
    logic [17:0] wdata;
    logic [17:0] rdata;
    logic        rdata_oe;

    logic [17:0] ref_mem [DEPTH];
    logic [AW-1:0] exp_a [6];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bsram_ctrl #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .adv_n(adv_n), .sel_main_n(sel_main_n), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
        .order_xor(order_xor), .pipe_sel(pipe_sel), .oe_n(oe_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_oe(input string req, input logic exp);
        chk(req, {17'b0, rdata_oe}, {17'b0, exp});
    endtask

    task automatic chk_rd(input string req, input logic [17:0] exp);
        chk_oe(req, 1'b1);
        chk(req, rdata, exp);
    endtask

    task automatic idle_in();
        strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
        sel_main_n = 0; sel_lo_n = 0; sel_hi = 1;
        wr_all_n = 1; wr_byte_n = 1; lane_n = 2'b11;
        oe_n = 0; wdata = '0; addr = '0;
    endtask

    task automatic deselect();
        idle_in(); strb_ctl_n = 0; sel_hi = 0;
        tick();
        idle_in();
    endtask

    task automatic ctl_write(input logic [AW-1:0] a, input logic [17:0] d);
        idle_in(); strb_ctl_n = 0; addr = a; wr_all_n = 0; wdata = d;
        tick();
        ref_mem[a] = d;
        idle_in();
    endtask

    // Single flow-through read through the processor strobe, then deselect.
    task automatic cpu_read_chk(input string req, input logic [AW-1:0] a);
        pipe_sel = 0;
        idle_in(); strb_cpu_n = 0; addr = a;
        tick();
        chk_rd(req, ref_mem[a]);
        deselect();
        tick();
    endtask

    task automatic t_reset_state();
        chk_oe("R11 reset", 1'b0);
        rst_n = 1;
        tick();
        chk_oe("R11 after release", 1'b0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 4; i++) ctl_write(AW'(32 + i), 18'h01000 + 18'(i) * 18'h0111);
        deselect();
        cpu_read_chk("R3 whole write", AW'(33));
    endtask

    // Burst write through the controller strobe, linear order from offset 2.
    task automatic t_ctl_burst_write();
        order_xor = 0; pipe_sel = 0;
        idle_in(); strb_ctl_n = 0; addr = AW'(42); wr_all_n = 0; wdata = 18'h0A0A0;
        tick(); ref_mem[42] = 18'h0A0A0;
        chk_oe("R8 write cycle drivers off", 1'b0);
        idle_in(); adv_n = 0; wr_all_n = 0; wdata = 18'h0B0B1;
        tick(); ref_mem[43] = 18'h0B0B1;
        idle_in(); adv_n = 0; wr_all_n = 0; wdata = 18'h0C0C2;
        tick(); ref_mem[40] = 18'h0C0C2;
        idle_in(); adv_n = 1; wr_all_n = 0; wdata = 18'h0D0D3;
        tick(); ref_mem[40] = 18'h0D0D3;
        deselect();
        cpu_read_chk("R3 ctl start write", AW'(42));
        cpu_read_chk("R5 continue write", AW'(43));
        cpu_read_chk("R5 suspend write wraps R6", AW'(40));
    endtask

    // Burst read from offset 1 of the group at 32.
    task automatic t_burst_read(input logic ord, input logic pipe);
        logic [1:0] cnt;
        logic [1:0] lsb;
        cnt = 0;
        order_xor = ord; pipe_sel = pipe;
        for (int e = 0; e < 6; e++) begin
            idle_in();
            if (e == 0) begin
                strb_cpu_n = 0; addr = AW'(33); adv_n = 0;
                wr_all_n = 0; wr_byte_n = 0; lane_n = 2'b00; wdata = 18'h3FFFF;
            end else begin
                adv_n = (e == 3) ? 1'b1 : 1'b0;
                if (adv_n == 1'b0) cnt = cnt + 2'd1;
                if (e == 2) begin
                    strb_cpu_n = 0; sel_main_n = 1;
                end
            end
            lsb = ord ? (2'd1 ^ cnt) : (2'd1 + cnt);
            exp_a[e] = {4'b1000, lsb};
            tick();
            if (!pipe) begin
                chk_rd(ord ? "R6 interleaved R4 R2" : "R6 linear R4 R2", ref_mem[exp_a[e]]);
            end else if (e == 0) begin
                chk_oe("R10 pipelined latency", 1'b0);
            end else begin
                chk_rd(ord ? "R10 R6 interleaved R5" : "R10 R6 linear R5", ref_mem[exp_a[e-1]]);
            end
        end
        deselect();
        if (pipe) chk_rd("R9 pipelined last beat", ref_mem[exp_a[5]]);
        else chk_oe("R9 flow deselect", 1'b0);
        tick();
        chk_oe("R9 idle", 1'b0);
    endtask

    task automatic t_byte_write();
        logic [17:0] v;
        pipe_sel = 0;
        ctl_write(AW'(48), 18'h2AB55);
        idle_in(); strb_ctl_n = 0; addr = AW'(48); wr_byte_n = 0; lane_n = 2'b10; wdata = 18'h12345;
        tick();
        v = {ref_mem[48][17:9], 9'h145};
        ref_mem[48] = v;
        chk_oe("R8 byte write blocks", 1'b0);
        idle_in(); strb_ctl_n = 0; addr = AW'(48); lane_n = 2'b00; wdata = 18'h3FFFF;
        tick();
        chk_rd("R7 lanes without qualifier read", v);
        idle_in(); strb_ctl_n = 0; addr = AW'(48); wr_byte_n = 0; wdata = 18'h3FFFF;
        tick();
        chk_rd("R7 qualifier without lanes read", v);
        idle_in(); strb_ctl_n = 0; addr = AW'(48); wr_byte_n = 0; lane_n = 2'b01; wdata = 18'h25A00;
        tick();
        v = {9'h12D, v[8:0]};
        ref_mem[48] = v;
        deselect();
        cpu_read_chk("R7 upper lane write", AW'(48));
    endtask

    task automatic t_turnaround();
        pipe_sel = 1; order_xor = 1;
        idle_in(); strb_cpu_n = 0; addr = AW'(34);
        tick();
        idle_in(); wr_byte_n = 0; lane_n = 2'b00; wdata = 18'h1C3C3;
        tick();
        ref_mem[34] = 18'h1C3C3;
        chk_oe("R8 pipelined read blocked by write", 1'b0);
        idle_in();
        tick();
        chk_oe("R8 no read behind write", 1'b0);
        tick();
        chk_rd("R5 suspend write then read", 18'h1C3C3);
        deselect();
        tick();
    endtask

    task automatic t_deselect();
        pipe_sel = 0;
        idle_in(); strb_cpu_n = 0; addr = AW'(32);
        tick();
        chk_rd("R1 flow read", ref_mem[32]);
        idle_in(); strb_ctl_n = 0; sel_main_n = 1;
        tick();
        chk_oe("R2 ctl strobe deselects", 1'b0);
        idle_in(); strb_cpu_n = 0; sel_main_n = 1; addr = AW'(33);
        tick();
        chk_oe("R2 blocked cpu strobe no start", 1'b0);
        pipe_sel = 1;
        idle_in(); strb_cpu_n = 0; addr = AW'(35);
        tick();
        idle_in(); strb_cpu_n = 0; sel_lo_n = 1;
        tick();
        chk_rd("R9 single cycle data", ref_mem[35]);
        idle_in();
        tick();
        chk_oe("R9 pipelined off", 1'b0);
        pipe_sel = 0;
        idle_in(); strb_cpu_n = 0; addr = AW'(35);
        tick();
        idle_in(); strb_cpu_n = 0; sel_hi = 0;
        tick();
        chk_oe("R9 sel_hi low", 1'b0);
    endtask

    task automatic t_oe();
        pipe_sel = 0;
        idle_in(); strb_cpu_n = 0; addr = AW'(43);
        tick();
        chk_rd("R12 baseline", ref_mem[43]);
        idle_in(); oe_n = 1;
        #1;
        chk_oe("R12 oe_n high", 1'b0);
        oe_n = 0;
        #1;
        chk_oe("R12 oe_n low", 1'b1);
        deselect();
        tick();
    endtask

    task automatic t_reset_mid();
        pipe_sel = 0;
        idle_in(); strb_cpu_n = 0; addr = AW'(32);
        tick();
        chk_oe("R11 read before reset", 1'b1);
        idle_in(); rst_n = 0;
        tick();
        chk_oe("R11 reset drops drive", 1'b0);
        rst_n = 1;
        tick();
        chk_oe("R11 closed after reset", 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; order_xor = 1; pipe_sel = 0;
        idle_in();
        repeat (3) tick();
        t_reset_state();
        t_fill();
        t_ctl_burst_write();
        t_burst_read(1'b1, 1'b0);
        t_burst_read(1'b0, 1'b0);
        t_burst_read(1'b1, 1'b1);
        t_burst_read(1'b0, 1'b1);
        t_byte_write();
        t_turnaround();
        t_deselect();
        t_oe();
        t_reset_mid();
        finish_run();
    end
endmodule